// File: doc/BRIEF.md
# MESI Snooping Coherence Controller

This block keeps one private cache coherent with its peers on a shared snooping bus. It holds a small direct-mapped array in which each line carries a tag, one data word and one of four coherence states: Invalid, Shared, Exclusive or Modified. Processor reads and writes are served from the array when the state allows it. Otherwise the block requests the bus and, once granted, issues a read, a read-for-ownership, an upgrade or a write-back.

Transactions from other caches arrive on the snoop input. The block answers them in the same cycle. It raises its contribution to the wired-OR shared line when it holds a valid copy of a snooped read, and it flushes the line's word when it owns dirty data. It also flushes when it is the only clean copy and cache-to-cache supply is enabled. The shared line sampled at grant time decides whether a read miss fills as Shared or as Exclusive. This is why a later write to an Exclusive line costs no bus cycle.

The bus arbiter guarantees that a snoop and a grant to this cache never fall in the same cycle. Processor requests are held stable until `cpu_ready` pulses.

Top module: `coh_mesi_ctl`

## Requirements
- R1: After reset every line is Invalid; `cpu_ready`, `bus_req`, `shared_out` and `flush_valid` are low and `bus_cmd` is 0.
- R2: A read miss requests the bus with command code 1 (read). At the grant the line fills with `bus_fill` and becomes Exclusive if `shared_in` is low, or Shared if it is high.
- R3: A write miss requests the bus with command code 2 (read-for-ownership) and leaves the line Modified, holding the written word.
- R4: A write to an Exclusive line makes it Modified with no bus request, and `cpu_ready` pulses on the cycle after acceptance.
- R5: A write to a Shared line requests the bus with command code 3 (upgrade) rather than code 2, and leaves the line Modified.
- R6: Reads that hit a Shared, Exclusive or Modified line, and writes that hit a Modified line, make no bus request. `cpu_ready` is a one-cycle pulse on the cycle after acceptance, with `cpu_rdata` holding the line word (read) or the written word (write).
- R7: A snooped read (`snp_cmd` 1) that hits a Modified line asserts `flush_valid` in the same cycle with the line word on `flush_data`, and the line becomes Shared.
- R8: A snooped read-for-ownership (`snp_cmd` 2) that hits any valid line makes it Invalid. A Modified line flushes its word in that cycle.
- R9: With cache-to-cache supply enabled, an Exclusive line flushes on a snooped read or read-for-ownership. A Shared line never flushes.
- R10: `shared_out` is high exactly in the cycles of a snooped read whose address hits a valid line.
- R11: A snooped upgrade (`snp_cmd` 3) invalidates a Shared copy. It has no effect on Exclusive or Modified lines and never flushes.
- R12: A miss whose victim is Modified first issues a write-back (command code 4) with the victim's address and word, then the fill command. Exclusive or Shared victims are replaced with no write-back.
- R13: While waiting for the grant, `bus_req` stays high, command and address stay stable, `cpu_ready` stays low and the line state does not change.
- R14: If a snoop invalidates a Shared line while its upgrade is waiting for the grant, the pending command becomes a read-for-ownership.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address; low bits index the line |
| cpu_wdata | input | DATA_W | Write word |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Read word or echoed write word |
| bus_req | output | 1 | Bus request |
| bus_cmd | output | 3 | 0 none, 1 read, 2 read-for-ownership, 3 upgrade, 4 write-back |
| bus_addr | output | ADDR_W | Transaction address |
| bus_wdata | output | DATA_W | Write-back word |
| bus_gnt | input | 1 | Grant; the transaction completes in this cycle |
| bus_fill | input | DATA_W | Fill word for a read |
| shared_in | input | 1 | Sampled wired-OR shared line |
| shared_out | output | 1 | This cache's drive onto the shared line |
| snp_valid | input | 1 | Snooped transaction present |
| snp_cmd | input | 3 | Snooped command, same codes as `bus_cmd` |
| snp_addr | input | ADDR_W | Snooped address |
| flush_valid | output | 1 | Line word supplied on `flush_data` |
| flush_data | output | DATA_W | Flushed word |

## Verification
The hardest condition to reach from the ports is a snoop landing on a line whose own transaction is already waiting for the bus. Two cases matter: a Shared line being upgraded, and a Modified victim waiting for its write-back. The bench holds back the grant while it injects a snooped read-for-ownership on the pending address, then checks that the upgrade has turned into a read-for-ownership. A long arithmetic sweep mixes reads, writes and the three snoop kinds over three tags aliasing onto four lines, against a state model kept in the bench. This drives every line through every state pair, including evictions of each victim state.

// File: rtl/coh_mesi_pkg.sv
package coh_mesi_pkg;
   typedef enum logic [1:0] {
      LS_INV = 2'd0,
      LS_SHR = 2'd1,
      LS_EXC = 2'd2,
      LS_MOD = 2'd3
   } line_st_t;

   typedef enum logic [2:0] {
      BC_IDLE  = 3'd0,
      BC_READ  = 3'd1,
      BC_READX = 3'd2,
      BC_UPGR  = 3'd3,
      BC_WBACK = 3'd4
   } bus_op_t;
endpackage

// File: rtl/coh_line_store.sv
module coh_line_store
   import coh_mesi_pkg::*;
#(
   parameter int TAG_W  = 6,
   parameter int DATA_W = 8,
   parameter int LINES  = 4,
   localparam int IDX_W = $clog2(LINES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  pa_idx,
   output line_st_t          pa_st,
   output logic [TAG_W-1:0]  pa_tag,
   output logic [DATA_W-1:0] pa_data,
   input  logic [IDX_W-1:0]  sb_idx,
   output line_st_t          sb_st,
   output logic [TAG_W-1:0]  sb_tag,
   output logic [DATA_W-1:0] sb_data,
   input  logic              pw_en,
   input  logic [IDX_W-1:0]  pw_idx,
   input  line_st_t          pw_st,
   input  logic [TAG_W-1:0]  pw_tag,
   input  logic [DATA_W-1:0] pw_data,
   input  logic              sw_en,
   input  logic [IDX_W-1:0]  sw_idx,
   input  line_st_t          sw_st
);
   line_st_t          st_q   [LINES];
   logic [TAG_W-1:0]  tag_q  [LINES];
   logic [DATA_W-1:0] data_q [LINES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < LINES; k++) begin
            st_q[k]   <= LS_INV;
            tag_q[k]  <= '0;
            data_q[k] <= '0;
         end
      end else begin
         for (int k = 0; k < LINES; k++) begin
            // snoop update wins over the processor side on the state field
            if (sw_en && sw_idx == IDX_W'(k))
               st_q[k] <= sw_st;
            else if (pw_en && pw_idx == IDX_W'(k))
               st_q[k] <= pw_st;
            if (pw_en && pw_idx == IDX_W'(k)) begin
               tag_q[k]  <= pw_tag;
               data_q[k] <= pw_data;
            end
         end
      end
   end

   assign pa_st   = st_q[pa_idx];
   assign pa_tag  = tag_q[pa_idx];
   assign pa_data = data_q[pa_idx];
   assign sb_st   = st_q[sb_idx];
   assign sb_tag  = tag_q[sb_idx];
   assign sb_data = data_q[sb_idx];
endmodule

// File: rtl/coh_snoop_resp.sv
module coh_snoop_resp
   import coh_mesi_pkg::*;
#(
   parameter int TAG_W  = 6,
   parameter int DATA_W = 8,
   parameter bit C2C_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              snp_valid,
   input  logic [2:0]        snp_cmd,
   input  logic [TAG_W-1:0]  snp_tag,
   input  line_st_t          ln_st,
   input  logic [TAG_W-1:0]  ln_tag,
   input  logic [DATA_W-1:0] ln_data,
   output logic              shared_out,
   output logic              flush_valid,
   output logic [DATA_W-1:0] flush_data,
   output logic              upd_en,
   output line_st_t          upd_st
);
   logic hit;
   logic exc_supplies;

   assign hit = snp_valid && (ln_st != LS_INV) && (ln_tag == snp_tag);

   generate
      if (C2C_EN) begin : g_c2c
         assign exc_supplies = (ln_st == LS_EXC);
      end else begin : g_mem_only
         assign exc_supplies = 1'b0;
      end
   endgenerate

   always_comb begin
      shared_out  = 1'b0;
      flush_valid = 1'b0;
      upd_en      = 1'b0;
      upd_st      = ln_st;
      if (hit) begin
         unique case (bus_op_t'(snp_cmd))
            BC_READ: begin
               shared_out  = 1'b1;
               flush_valid = (ln_st == LS_MOD) || exc_supplies;
               upd_en      = (ln_st != LS_SHR);
               upd_st      = LS_SHR;
            end
            BC_READX: begin
               flush_valid = (ln_st == LS_MOD) || exc_supplies;
               upd_en      = 1'b1;
               upd_st      = LS_INV;
            end
            BC_UPGR: begin
               upd_en = (ln_st == LS_SHR);
               upd_st = LS_INV;
            end
            default: ;
         endcase
      end
   end

   assign flush_data = flush_valid ? ln_data : '0;

   // R7: a dirty owner supplies its word whenever a read or read-for-ownership hits it
   a_r7_dirty_flush: assert property (@(posedge clk) disable iff (!rst_n)
      (snp_valid && ln_st == LS_MOD && ln_tag == snp_tag &&
       (snp_cmd == BC_READ || snp_cmd == BC_READX))
      |-> (flush_valid && flush_data == ln_data));

   // R10: the shared line is driven only for a snooped read
   a_r10_shared_only_read: assert property (@(posedge clk) disable iff (!rst_n)
      shared_out |-> (snp_valid && snp_cmd == BC_READ));
endmodule

// File: rtl/coh_proc_seq.sv
module coh_proc_seq
   import coh_mesi_pkg::*;
#(
   parameter int TAG_W  = 6,
   parameter int DATA_W = 8,
   parameter int IDX_W  = 2,
   localparam int ADDR_W = TAG_W + IDX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic              cpu_ready,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              bus_req,
   output logic [2:0]        bus_cmd,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_gnt,
   input  logic [DATA_W-1:0] bus_fill,
   input  logic              shared_in,
   input  logic              snp_busy,
   output logic [IDX_W-1:0]  pa_idx,
   input  line_st_t          pa_st,
   input  logic [TAG_W-1:0]  pa_tag,
   input  logic [DATA_W-1:0] pa_data,
   output logic              pw_en,
   output line_st_t          pw_st,
   output logic [TAG_W-1:0]  pw_tag,
   output logic [DATA_W-1:0] pw_data
);
   typedef enum logic {PS_IDLE, PS_BUS} ps_t;

   ps_t               fsm_q;
   logic              ready_q;
   logic [DATA_W-1:0] rdata_q;
   logic              we_q;
   logic [TAG_W-1:0]  tag_q;
   logic [IDX_W-1:0]  idx_q;
   logic [DATA_W-1:0] wdata_q;

   logic              in_idle, accepting;
   logic              c_we;
   logic [TAG_W-1:0]  c_tag;
   logic [IDX_W-1:0]  c_idx;
   logic [DATA_W-1:0] c_wdata;
   logic              hit, go, done_nobus, gnt_ok, complete;
   bus_op_t           cmd;
   logic [DATA_W-1:0] rvalue;

   assign in_idle   = (fsm_q == PS_IDLE);
   assign accepting = in_idle && !ready_q;
   assign c_we      = accepting ? cpu_we : we_q;
   assign c_tag     = accepting ? cpu_addr[ADDR_W-1:IDX_W] : tag_q;
   assign c_idx     = accepting ? cpu_addr[IDX_W-1:0] : idx_q;
   assign c_wdata   = accepting ? cpu_wdata : wdata_q;
   assign pa_idx    = c_idx;

   assign hit = (pa_st != LS_INV) && (pa_tag == c_tag);

   // command is recomputed from the live line state so that snoops are honoured
   always_comb begin
      if (!hit && pa_st == LS_MOD)  cmd = BC_WBACK;
      else if (!hit)                cmd = c_we ? BC_READX : BC_READ;
      else if (c_we && pa_st == LS_SHR) cmd = BC_UPGR;
      else                          cmd = BC_IDLE;
   end

   assign go         = accepting && cpu_req && !snp_busy;
   assign done_nobus = (go || (fsm_q == PS_BUS && !snp_busy)) && cmd == BC_IDLE;
   assign gnt_ok     = (fsm_q == PS_BUS) && bus_gnt && !snp_busy && cmd != BC_IDLE;
   assign complete   = done_nobus || (gnt_ok && cmd != BC_WBACK);

   assign bus_req   = (fsm_q == PS_BUS) && cmd != BC_IDLE;
   assign bus_cmd   = bus_req ? cmd : BC_IDLE;
   assign bus_addr  = (cmd == BC_WBACK) ? {pa_tag, c_idx} : {c_tag, c_idx};
   assign bus_wdata = (cmd == BC_WBACK) ? pa_data : c_wdata;

   always_comb begin
      pw_en   = 1'b0;
      pw_st   = pa_st;
      pw_tag  = c_tag;
      pw_data = c_wdata;
      if (done_nobus && c_we) begin
         pw_en = 1'b1;
         pw_st = LS_MOD;
      end else if (gnt_ok) begin
         pw_en = 1'b1;
         unique case (cmd)
            BC_WBACK: begin
               pw_st   = LS_INV;
               pw_tag  = pa_tag;
               pw_data = pa_data;
            end
            BC_READ: begin
               pw_st   = shared_in ? LS_SHR : LS_EXC;
               pw_data = bus_fill;
            end
            default: pw_st = LS_MOD;
         endcase
      end
   end

   assign rvalue = c_we ? c_wdata : ((cmd == BC_READ) ? bus_fill : pa_data);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fsm_q   <= PS_IDLE;
         ready_q <= 1'b0;
         rdata_q <= '0;
         we_q    <= 1'b0;
         tag_q   <= '0;
         idx_q   <= '0;
         wdata_q <= '0;
      end else begin
         ready_q <= complete;
         if (complete) rdata_q <= rvalue;
         if (go) begin
            we_q    <= cpu_we;
            tag_q   <= cpu_addr[ADDR_W-1:IDX_W];
            idx_q   <= cpu_addr[IDX_W-1:0];
            wdata_q <= cpu_wdata;
         end
         if (go && cmd != BC_IDLE) fsm_q <= PS_BUS;
         else if (complete)        fsm_q <= PS_IDLE;
      end
   end

   assign cpu_ready = ready_q;
   assign cpu_rdata = rdata_q;

   // R2: a granted read fill leaves the state chosen by the sampled shared line
   a_r2_fill_state: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_ok && cmd == BC_READ)
      |=> (pa_st == ($past(shared_in) ? LS_SHR : LS_EXC)));

   // R4: a write hit on an Exclusive line completes without touching the bus
   a_r4_exclusive_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (go && cpu_we && hit && pa_st == LS_EXC) |=> (cpu_ready && !bus_req));

   // R6: completion is a single-cycle pulse
   a_r6_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ready |=> !cpu_ready);

   // R13: a request without a grant is held, stable when no snoop intervenes
   a_r13_req_held: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_gnt) |=> bus_req);
   a_r13_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_gnt && !snp_busy)
      |=> ($stable(bus_cmd) && $stable(bus_addr) && !cpu_ready));
endmodule

// File: rtl/coh_mesi_ctl.sv
module coh_mesi_ctl
   import coh_mesi_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8,
   parameter int LINES  = 4,
   parameter bit C2C_EN = 1'b1,
   localparam int IDX_W = $clog2(LINES),
   localparam int TAG_W = ADDR_W - IDX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic              cpu_ready,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              bus_req,
   output logic [2:0]        bus_cmd,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_gnt,
   input  logic [DATA_W-1:0] bus_fill,
   input  logic              shared_in,
   output logic              shared_out,
   input  logic              snp_valid,
   input  logic [2:0]        snp_cmd,
   input  logic [ADDR_W-1:0] snp_addr,
   output logic              flush_valid,
   output logic [DATA_W-1:0] flush_data
);
   generate
      if (LINES < 2 || (LINES & (LINES - 1)) != 0) begin : g_bad_lines
         $error("LINES must be a power of two and at least 2");
      end
      if (TAG_W < 1) begin : g_bad_addr
         $error("ADDR_W must exceed the index width");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("DATA_W must be positive");
      end
   endgenerate

   logic [IDX_W-1:0]  pa_idx;
   line_st_t          pa_st, sb_st, pw_st, sw_st;
   logic [TAG_W-1:0]  pa_tag, sb_tag, pw_tag;
   logic [DATA_W-1:0] pa_data, sb_data, pw_data;
   logic              pw_en, sw_en;

   coh_line_store #(.TAG_W(TAG_W), .DATA_W(DATA_W), .LINES(LINES)) u_store (
      .clk(clk), .rst_n(rst_n),
      .pa_idx(pa_idx), .pa_st(pa_st), .pa_tag(pa_tag), .pa_data(pa_data),
      .sb_idx(snp_addr[IDX_W-1:0]), .sb_st(sb_st), .sb_tag(sb_tag), .sb_data(sb_data),
      .pw_en(pw_en), .pw_idx(pa_idx), .pw_st(pw_st), .pw_tag(pw_tag), .pw_data(pw_data),
      .sw_en(sw_en), .sw_idx(snp_addr[IDX_W-1:0]), .sw_st(sw_st)
   );

   coh_snoop_resp #(.TAG_W(TAG_W), .DATA_W(DATA_W), .C2C_EN(C2C_EN)) u_snoop (
      .clk(clk), .rst_n(rst_n),
      .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_tag(snp_addr[ADDR_W-1:IDX_W]),
      .ln_st(sb_st), .ln_tag(sb_tag), .ln_data(sb_data),
      .shared_out(shared_out), .flush_valid(flush_valid), .flush_data(flush_data),
      .upd_en(sw_en), .upd_st(sw_st)
   );

   coh_proc_seq #(.TAG_W(TAG_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_proc (
      .clk(clk), .rst_n(rst_n),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
      .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_gnt(bus_gnt), .bus_fill(bus_fill), .shared_in(shared_in),
      .snp_busy(snp_valid),
      .pa_idx(pa_idx), .pa_st(pa_st), .pa_tag(pa_tag), .pa_data(pa_data),
      .pw_en(pw_en), .pw_st(pw_st), .pw_tag(pw_tag), .pw_data(pw_data)
   );
endmodule

// File: tb/sim_coh_mesi_ctl.sv
module sim_coh_mesi_ctl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cpu_req = 0, cpu_we = 0;
   logic [7:0] cpu_addr = 0, cpu_wdata = 0;
   logic       cpu_ready;
   logic [7:0] cpu_rdata;
   logic       bus_req;
   logic [2:0] bus_cmd;
   logic [7:0] bus_addr, bus_wdata;
   logic       bus_gnt = 0;
   logic [7:0] bus_fill = 0;
   logic       shared_in = 0, shared_out;
   logic       snp_valid = 0;
   logic [2:0] snp_cmd = 0;
   logic [7:0] snp_addr = 0;
   logic       flush_valid;
   logic [7:0] flush_data;

   int checks = 0, failures = 0;
   int         mst  [4];
   logic [5:0] mtag [4];
   logic [7:0] mdata[4];

   always #5 clk = ~clk;

   coh_mesi_ctl u0 (.*);

   task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   task automatic grant(input bit sh, input logic [7:0] fill);
      bus_gnt = 1; shared_in = sh; bus_fill = fill;
      @(negedge clk);
      bus_gnt = 0; shared_in = 0;
   endtask

   task automatic cpu_op(input bit we, input logic [7:0] a, input logic [7:0] d,
                         input bit sh, input logic [7:0] fill);
      int ix = int'(a[1:0]);
      bit hit = (mst[ix] != 0) && (mtag[ix] == a[7:2]);
      bit wb = !hit && (mst[ix] == 3);
      int ncmd = !hit ? (we ? 2 : 1) : ((we && mst[ix] == 1) ? 3 : 0);
      string rq = (ncmd == 1) ? "R2" : (ncmd == 2) ? "R3" : (ncmd == 3) ? "R5" :
                  (we && mst[ix] == 2) ? "R4" : "R6";
      logic [7:0] exp_rd = we ? d : ((ncmd == 1) ? fill : mdata[ix]);
      @(negedge clk);
      cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
      @(negedge clk);
      if (wb) begin
         chk("R12", bus_req, 1); chk("R12", bus_cmd, 4);
         chk("R12", bus_addr, {mtag[ix], a[1:0]}); chk("R12", bus_wdata, mdata[ix]);
         grant(0, 8'h00);
         chk("R12", cpu_ready, 0);
      end
      if (ncmd != 0) begin
         chk(rq, bus_req, 1); chk(rq, bus_cmd, ncmd); chk(rq, bus_addr, a);
         chk("R13", cpu_ready, 0);
         @(negedge clk);
         chk("R13", bus_req, 1); chk("R13", bus_cmd, ncmd); chk("R13", cpu_ready, 0);
         grant(sh, fill);
      end else begin
         chk(rq, bus_req, 0);
      end
      chk(rq, cpu_ready, 1);
      chk(rq, cpu_rdata, exp_rd);
      if (we) begin mst[ix] = 3; mtag[ix] = a[7:2]; mdata[ix] = d; end
      else if (ncmd == 1) begin mst[ix] = sh ? 1 : 2; mtag[ix] = a[7:2]; mdata[ix] = fill; end
      cpu_req = 0;
      @(negedge clk);
      chk("R6", cpu_ready, 0);
   endtask

   task automatic snoop(input logic [2:0] c, input logic [7:0] a);
      int ix = int'(a[1:0]);
      bit hit = (mst[ix] != 0) && (mtag[ix] == a[7:2]);
      bit exp_sh = hit && c == 1;
      bit exp_fl = hit && (c == 1 || c == 2) && (mst[ix] == 3 || mst[ix] == 2);
      string rq = (mst[ix] == 2) ? "R9" : (c == 1) ? "R7" : (c == 2) ? "R8" : "R11";
      @(negedge clk);
      snp_valid = 1; snp_cmd = c; snp_addr = a;
      #1;
      chk("R10", shared_out, exp_sh);
      chk(rq, flush_valid, exp_fl);
      if (exp_fl) chk(rq, flush_data, mdata[ix]);
      @(negedge clk);
      snp_valid = 0; snp_cmd = 0;
      if (hit) begin
         if (c == 1) mst[ix] = 1;
         else if (c == 2) mst[ix] = 0;
         else if (c == 3 && mst[ix] == 1) mst[ix] = 0;
      end
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      for (int k = 0; k < 4; k++) begin mst[k] = 0; mtag[k] = 0; mdata[k] = 0; end
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk("R1", cpu_ready, 0); chk("R1", bus_req, 0); chk("R1", bus_cmd, 0);
      chk("R1", shared_out, 0); chk("R1", flush_valid, 0);
      for (int k = 0; k < 4; k++) snoop(3'd1, 8'(k));   // R1: all lines invalid
      // directed path through every state
      cpu_op(0, 8'h04, 8'h00, 0, 8'h11);   // R2 fill Exclusive
      cpu_op(1, 8'h04, 8'h22, 0, 8'h00);   // R4 silent write
      snoop(3'd1, 8'h04);                  // R7 flush, Modified to Shared
      cpu_op(1, 8'h04, 8'h33, 0, 8'h00);   // R5 upgrade
      cpu_op(0, 8'h05, 8'h00, 1, 8'h44);   // R2 fill Shared
      snoop(3'd1, 8'h05);                  // R9 Shared never flushes
      snoop(3'd3, 8'h05);                  // R11 upgrade invalidates Shared
      cpu_op(0, 8'h05, 8'h00, 0, 8'h55);   // Exclusive again
      snoop(3'd3, 8'h05);                  // R11 no effect on Exclusive
      cpu_op(1, 8'h05, 8'h66, 0, 8'h00);   // R4 still silent
      cpu_op(0, 8'h09, 8'h00, 0, 8'h77);   // R12 write-back then fill
      snoop(3'd2, 8'h09);                  // R9 Exclusive supplies on read-for-ownership
      // R14: snoop invalidates a Shared line while its upgrade waits
      cpu_op(0, 8'h08, 8'h00, 1, 8'h12);
      @(negedge clk);
      cpu_req = 1; cpu_we = 1; cpu_addr = 8'h08; cpu_wdata = 8'h9A;
      @(negedge clk);
      chk("R14", bus_cmd, 3);
      snp_valid = 1; snp_cmd = 3'd2; snp_addr = 8'h08;
      @(negedge clk);
      snp_valid = 0; snp_cmd = 0;
      chk("R14", bus_req, 1); chk("R14", bus_cmd, 2);
      grant(0, 8'h00);
      chk("R14", cpu_ready, 1); chk("R14", cpu_rdata, 8'h9A);
      cpu_req = 0;
      mst[0] = 3; mtag[0] = 6'd2; mdata[0] = 8'h9A;
      @(negedge clk);
      // arithmetic sweep over three aliasing tags and four lines
      for (int i = 0; i < 700; i++) begin
         int k = (i * 7 + i / 9) % 6;
         logic [7:0] a = {4'd0, 2'(((i * 5) / 4) % 3), 2'((i * 3 + i / 4) % 4)};
         bit sh = (i % 3) == 0;
         case (k)
            0, 1: cpu_op(0, a, 8'h00, sh, 8'(i) ^ 8'h5A);
            2:    cpu_op(1, a, 8'(i * 3), sh, 8'h00);
            3:    snoop(3'd1, a);
            4:    snoop(3'd2, a);
            default: snoop(3'd3, a);
         endcase
      end
      finish_run();
   end
endmodule